// File: doc/BRIEF.md
# Halfword-select signed multiplier

This block is a single-stage signed multiplier for a datapath that handles packed 16-bit pairs held in 32-bit words. It has two modes. In halfword mode it takes one 16-bit half from each operand, picking the half of each operand separately, and returns their full 32-bit signed product. In word mode it multiplies the whole first operand, read as a signed 32-bit integer, by one signed 16-bit half of the second operand. The product is then 48 bits wide, and the block returns only its upper 32 bits, bits [47:16].

Operands enter through a valid/ready stream and results leave through another, with one register stage between them. A beat is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` in the next cycle. The result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the block keeps that result and `out_valid` unchanged and holds `in_ready` low. This back-pressure reaches the producer in the same cycle. When the consumer takes a result, the block can accept a new beat on that same edge. The block raises no flags of any kind.

Top module: `halfsel_smul`

## Requirements
- R1: In halfword mode (`in_mode` = 0), `in_sel_a` picks a half of `in_op_a` and `in_sel_b` picks a half of `in_op_b`, independently of each other. A select value of 0 picks bits [15:0] and a value of 1 picks bits [31:16].
- R2: In halfword mode, both chosen halves are read as signed 16-bit integers and the result is their complete 32-bit signed product. For example, -32768 × -32768 gives 0x40000000.
- R3: In word mode (`in_mode` = 1), all 32 bits of `in_op_a` are read as a signed integer and multiplied by the signed 16-bit half of `in_op_b` chosen by `in_sel_b` (0 picks [15:0], 1 picks [31:16]).
- R4: In word mode, the result is bits [47:16] of the 48-bit signed product. The low 16 bits are discarded by an arithmetic shift with no rounding, so -1 × 1 gives 0xFFFFFFFF.
- R5: In word mode, `in_sel_a` has no effect on the result.
- R6: A beat accepted on a clock edge raises `out_valid` after that edge and presents its result on `out_result`. `out_valid` drops after an edge on which the result is taken and no new beat is accepted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_result` stay unchanged and `in_ready` is low.
- R8: During and after reset, with no result pending, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operand beat is offered |
| in_ready | output | 1 | The block can accept a beat this cycle |
| in_mode | input | 1 | 0 = halfword × halfword, 1 = word × halfword |
| in_sel_a | input | 1 | Half select for the first operand (halfword mode only) |
| in_sel_b | input | 1 | Half select for the second operand |
| in_op_a | input | 32 | First operand |
| in_op_b | input | 32 | Second operand |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 32 | Product (full or upper 32 bits, depending on mode) |

## Verification
The hardest case to reach from the ports is a stalled result with a new beat already waiting at the input. The held product must stay intact, and the waiting beat must not slip into the register. The result must then hand over cleanly on the edge where `out_ready` returns. To reach this case, the stimulus runs a phase in which `out_ready` toggles pseudo-randomly while operands are offered back to back. A behavioural model that tracks the handshake compares valid, ready and result on every cycle. Directed beats cover the sign extremes in both modes and the truncation of negative word-mode products.

// File: rtl/hmul_pkg.sv
package hmul_pkg;
  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_WORD = 1'b1
  } hmul_mode_e;
endpackage

// File: rtl/hmul_operand_sel.sv
module hmul_operand_sel
  import hmul_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  hmul_mode_e                  mode,
  input  logic                        sel_a,
  input  logic                        sel_b,
  input  logic [WORD_W-1:0]           op_a,
  input  logic [WORD_W-1:0]           op_b,
  output logic signed [WORD_W-1:0]    mul_a,
  output logic signed [HALF_W-1:0]    mul_b
);
  localparam int NUM_HALVES = WORD_W / HALF_W;

  logic [HALF_W-1:0] a_half [NUM_HALVES];
  logic [HALF_W-1:0] b_half [NUM_HALVES];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_split
    assign a_half[h] = op_a[h*HALF_W +: HALF_W];
    assign b_half[h] = op_b[h*HALF_W +: HALF_W];
  end

  logic signed [HALF_W-1:0] a_pick;

  always_comb begin
    a_pick = a_half[sel_a];
    mul_b  = b_half[sel_b];
    if (mode == MODE_WORD) begin
      mul_a = op_a;
    end else begin
      mul_a = WORD_W'(a_pick);
    end
  end

  // R1: in halfword mode the widened first operand carries only a sign extension above the chosen half
  always_comb begin
    if (!$isunknown({mode, sel_a, op_a}) && mode == MODE_HALF) begin
      assert_half_sext_R1: assert (mul_a[WORD_W-1:HALF_W] == {(WORD_W-HALF_W){op_a[sel_a*HALF_W + HALF_W-1]}})
        else $error("first operand not sign extended from selected half");
    end
  end
endmodule

// File: rtl/hmul_mult_core.sv
module hmul_mult_core #(
  parameter int A_W = 32,
  parameter int B_W = 16
) (
  input  logic signed [A_W-1:0]     a,
  input  logic signed [B_W-1:0]     b,
  output logic signed [A_W+B_W-1:0] prod
);
  localparam int PROD_W = A_W + B_W;

  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;

  always_comb begin
    a_ext = PROD_W'(a);
    b_ext = PROD_W'(b);
    prod  = a_ext * b_ext;
  end
endmodule

// File: rtl/hmul_result_extract.sv
module hmul_result_extract
  import hmul_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  hmul_mode_e                        mode,
  input  logic signed [WORD_W+HALF_W-1:0]   prod,
  output logic [WORD_W-1:0]                 res
);
  localparam int PROD_W = WORD_W + HALF_W;

  always_comb begin
    if (mode == MODE_WORD) begin
      res = prod[PROD_W-1:HALF_W];
    end else begin
      res = prod[WORD_W-1:0];
    end
  end

  // R2: a half by half product never needs bits above the word; the discarded top bits match its sign
  always_comb begin
    if (!$isunknown({mode, prod}) && mode == MODE_HALF) begin
      assert_half_fits_R2: assert (prod[PROD_W-1:WORD_W-1] == {(HALF_W+1){prod[WORD_W-1]}})
        else $error("halfword product exceeds the result width");
    end
  end
endmodule

// File: rtl/hmul_out_stage.sv
module hmul_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("stalled result changed");

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("input accepted during stall");

  assert_valid_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready))
    else $error("result appeared without an accepted beat");

  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready)
    else $error("idle stage refuses input");
endmodule

// File: rtl/halfsel_smul.sv
module halfsel_smul
  import hmul_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_mode,
  input  logic              in_sel_a,
  input  logic              in_sel_b,
  input  logic [WORD_W-1:0] in_op_a,
  input  logic [WORD_W-1:0] in_op_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);
  localparam int PROD_W = WORD_W + HALF_W;

  hmul_mode_e               mode;
  logic signed [WORD_W-1:0] mul_a;
  logic signed [HALF_W-1:0] mul_b;
  logic signed [PROD_W-1:0] prod;
  logic [WORD_W-1:0]        res_next;

  assign mode = hmul_mode_e'(in_mode);

  hmul_operand_sel #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_sel (
    .mode  (mode),
    .sel_a (in_sel_a),
    .sel_b (in_sel_b),
    .op_a  (in_op_a),
    .op_b  (in_op_b),
    .mul_a (mul_a),
    .mul_b (mul_b)
  );

  hmul_mult_core #(.A_W(WORD_W), .B_W(HALF_W)) u_mul (
    .a    (mul_a),
    .b    (mul_b),
    .prod (prod)
  );

  hmul_result_extract #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_ext (
    .mode (mode),
    .prod (prod),
    .res  (res_next)
  );

  hmul_out_stage #(.DATA_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (res_next),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result)
  );
endmodule

// File: tb/sim_halfsel_smul.sv
`timescale 1ns/1ps
module sim_halfsel_smul;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic        in_sel_a = 1'b0;
  logic        in_sel_b = 1'b0;
  logic [31:0] in_op_a = '0;
  logic [31:0] in_op_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit rdy_random = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfsel_smul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_sel_a(in_sel_a), .in_sel_b(in_sel_b),
    .in_op_a(in_op_a), .in_op_b(in_op_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  function automatic logic [31:0] ref_mul(bit mode, bit sa, bit sb, logic [31:0] a, logic [31:0] b);
    longint pa, pb, p;
    pb = sb ? longint'($signed(b[31:16])) : longint'($signed(b[15:0]));
    if (!mode) begin
      pa = sa ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
      p = pa * pb;
    end else begin
      pa = longint'($signed(a));
      p = (pa * pb) >>> 16;
    end
    return p[31:0];
  endfunction

  // behavioural reference: one pending result, handshake tracked from driven inputs
  bit          m_valid = 0;
  logic [31:0] m_res = '0;
  string       m_tag = "R2";
  int          acc_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid = 1;
      m_res = ref_mul(in_mode, in_sel_a, in_sel_b, in_op_a, in_op_b);
      if (!in_mode) m_tag = (in_sel_a || in_sel_b) ? "R1" : "R2";
      else if (in_sel_a) m_tag = "R5";
      else if (m_res[31]) m_tag = "R4";
      else m_tag = "R3";
      acc_cnt++;
    end else if (out_ready) begin
      m_valid = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6", 32'(out_valid), 32'(m_valid), "out_valid");
      chk("R7", 32'(in_ready), 32'(!m_valid || out_ready), "in_ready");
      if (m_valid) chk(m_tag, out_result, m_res, "out_result");
    end
  end

  always @(posedge clk) begin
    #1;
    if (rdy_random) out_ready = ($urandom % 3) != 0;
  end

  task automatic send(bit mode, bit sa, bit sb, logic [31:0] a, logic [31:0] b);
    int n0;
    n0 = acc_cnt;
    in_mode = mode; in_sel_a = sa; in_sel_b = sb; in_op_a = a; in_op_b = b;
    in_valid = 1'b1;
    do begin @(posedge clk); #1; end while (acc_cnt == n0);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1;
    repeat (3) @(negedge clk);
    chk("R8", 32'(out_valid), 32'd0, "out_valid in reset");
    chk("R8", 32'(in_ready), 32'd1, "in_ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", 32'(out_valid), 32'd0, "out_valid after reset");
    chk("R8", 32'(in_ready), 32'd1, "in_ready after reset");
    @(posedge clk); #1;

    // R1/R2: half selection per operand, sign extremes
    send(0, 0, 0, 32'h1234_0003, 32'h5678_0005);
    send(0, 1, 0, 32'hFFFE_0003, 32'h5678_0007);
    send(0, 0, 1, 32'h1234_0009, 32'hFFFD_0005);
    send(0, 1, 1, 32'h8000_7FFF, 32'h8000_0001);
    send(0, 0, 0, 32'h0000_8000, 32'h0000_8000);
    send(0, 0, 0, 32'h0000_7FFF, 32'h0000_8000);
    // R3/R4: word by half, truncation toward negative infinity
    send(1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001);
    send(1, 0, 0, 32'h8000_0000, 32'h0000_8000);
    send(1, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_0000);
    send(1, 0, 0, 32'hFFFF_0001, 32'h0000_0003);
    send(1, 0, 1, 32'h0001_0000, 32'hFFFF_1234);
    // R5: sel_a toggled with identical operands must give identical results
    send(1, 0, 1, 32'hDEAD_BEEF, 32'hC0DE_0000);
    @(negedge clk); r0 = out_result;
    @(posedge clk); #1;
    send(1, 1, 1, 32'hDEAD_BEEF, 32'hC0DE_0000);
    @(negedge clk); r1 = out_result;
    chk("R5", r1, r0, "word mode with sel_a flipped");
    @(posedge clk); #1;

    // R7: explicit stall with a beat waiting
    out_ready = 1'b0;
    send(0, 0, 0, 32'h0000_0011, 32'h0000_0013);
    in_mode = 0; in_sel_a = 0; in_sel_b = 0; in_op_a = 32'h0000_0002; in_op_b = 32'h0000_0002;
    in_valid = 1'b1;
    idle(3);
    @(negedge clk);
    chk("R7", out_result, 32'h0000_0143, "held result during stall");
    chk("R7", 32'(in_ready), 32'd0, "in_ready during stall");
    @(posedge clk); #1;
    out_ready = 1'b1;
    idle(1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R6", out_result, 32'h0000_0004, "waiting beat after release");
    @(posedge clk); #1;
    idle(2);

    // random traffic with random back-pressure
    rdy_random = 1;
    for (int i = 0; i < 400; i++) begin
      send(1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom);
      if (($urandom % 4) == 0) idle(1);
    end
    rdy_random = 0;
    out_ready = 1'b1;
    idle(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule